// File: doc/BRIEF.md
# Lockstep Compare Safety Error Controller

This block watches a pair of cores running in lockstep. Every cycle it takes in the master core's output bus and the checker core's output bus, including address, write data and strobes. When compare checking is enabled and any bit differs, it raises a compare error. That error and a set of other safety error inputs land in a sticky status register. For each source, software chooses the reaction: an interrupt, a chip-level safety reset, both, or neither.

The safety reset is a fixed-length pulse driven on a dedicated output. The status register and a reset-cause flag sit in the always-on power-up domain, so the pulse does not clear them. After a restart, software can see which source fired and that the reset came from this monitor. The configuration registers sit in the functional domain and fall back to their defaults on a safety reset: reset enables, interrupt enables, and the interrupt priority level.

A diagnostic trigger lets software test the comparator. Writing it produces a one-cycle pulse that is wired only to the master core's interrupt input, so the two cores diverge and the comparator must trip. The cores and the interrupt controller are outside the block and are reached through plain ports.

Top module: `lockstep_safety_ctrl`

## Requirements
- R1: When `cmp_en` is 1 and `mst_bus` differs from `chk_bus` in any bit, status bit 5 (the compare-error source) becomes 1. When `cmp_en` is 0, a mismatch sets nothing.
- R2: A 1 on `ext_err[i]` sets status bit i. No other status bit changes.
- R3: Status bits (address 1) are sticky. Writing 1 to a bit clears it. The clear has no effect while that bit's source is still high in the same cycle.
- R4: Reset enable register (address 0), bit i: 1 lets a set status bit i start a safety reset; 0 masks it. Interrupt enable register (address 4), bit i: 1 drives `irq_o` high while status bit i is set. The two reactions are independent.
- R5: A safety reset drives `safety_rst_o` high for exactly 16 cycles. The status register keeps its value through the pulse.
- R6: Reset-cause register (address 2), bit 0: reads 0 after power-up, becomes 1 when a safety reset starts, and is cleared by writing 1.
- R7: Interrupt level register (address 3), bit 0: 1 means non-maskable, and that is the reset value. It is writable to 0 (maskable) and is driven on `irq_nmi_o`. A safety reset returns it to 1, and returns the reset-enable and interrupt-enable registers to 0.
- R8: Writing 1 to bit 0 at address 5 gives a one-cycle pulse on `diag_o`. When this pulse is fed into the master core only, the resulting bus divergence sets status bit 5.
- R9: If the reset enable for a source is written to 1 while that source's status bit is already set, a safety reset is generated.
- R10: Reads return the addressed register on `reg_rdata` one cycle after the address is presented. No register is reachable from more than one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-up reset (always-on domain) |
| cmp_en | input | 1 | Enables the lockstep comparison |
| mst_bus | input | BUS_W | Master core output bus |
| chk_bus | input | BUS_W | Checker core output bus |
| ext_err | input | N_SRC | Other safety error sources |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Registered read data |
| irq_o | output | 1 | Safety interrupt request |
| irq_nmi_o | output | 1 | Interrupt level, 1 = non-maskable |
| diag_o | output | 1 | Diagnostic pulse to the master core's interrupt input |
| safety_rst_o | output | 1 | Chip-level safety reset pulse |

## Verification
The checker assertions act on every cycle. They tie an enabled two-cycle-old bus mismatch to the compare error. They keep status bits from dropping without a write-1 clear. They allow no safety reset without an enabled, set source, and they hold the pulse to exactly 16 cycles. They also check that the cause flag sets at the pulse start, that the priority level returns to non-maskable during the pulse, and that the diagnostic pulse lasts one cycle.

Only the bench's scenarios can show the full reaction matrix across every source and every enable combination, and that status survives a reset it caused. They also show the full self-test, where the diagnostic pulse is looped into the master bus and the reset enable is set late from an interrupt handler.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    A_RSTCFG = 3'd0,
    A_STAT   = 3'd1,
    A_CAUSE  = 3'd2,
    A_IRQCTL = 3'd3,
    A_IRQEN  = 3'd4,
    A_DIAG   = 3'd5
  } lsc_addr_e;
endpackage

// File: rtl/lsc_compare.sv
module lsc_compare #(
  parameter int BUS_W = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [BUS_W-1:0] a,
  input  logic [BUS_W-1:0] b,
  output logic             err
);
  logic [BUS_W-1:0] a_q, b_q;
  logic             en_q;

  // Stage 1 registers both buses; stage 2 registers the XOR reduction.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q  <= '0;
      b_q  <= '0;
      en_q <= 1'b0;
      err  <= 1'b0;
    end else begin
      a_q  <= a;
      b_q  <= b;
      en_q <= en;
      err  <= en_q && (|(a_q ^ b_q));
    end
  end
endmodule

// File: rtl/lsc_pulse_gen.sv
module lsc_pulse_gen #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(RST_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && req) begin
      busy <= 1'b1;
      cnt  <= CW'(RST_LEN - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             func_rst,
  input  logic [N_SRC-1:0] src,
  input  logic             sres_busy,
  input  logic [2:0]       reg_addr,
  input  logic             reg_we,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic [N_SRC-1:0] stat_o,
  output logic [N_SRC-1:0] clr_o,
  output logic             cause_o,
  output logic             rst_req,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             diag_o
);
  logic [N_SRC-1:0] stat_q, cfg_q, irqen_q;
  logic             cause_q, busy_d;

  logic wr_stat, wr_cause;
  assign wr_stat  = reg_we && (reg_addr == A_STAT);
  assign wr_cause = reg_we && (reg_addr == A_CAUSE) && reg_wdata[0];
  assign clr_o    = wr_stat ? reg_wdata : '0;

  // Always-on domain: sticky status and reset cause.
  always_ff @(posedge clk) begin
    if (por_rst) begin
      stat_q  <= '0;
      cause_q <= 1'b0;
      busy_d  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_o) | src;
      busy_d <= sres_busy;
      if (sres_busy && !busy_d) cause_q <= 1'b1;
      else if (wr_cause)        cause_q <= 1'b0;
    end
  end

  // Functional domain: cleared by power-up or safety reset.
  always_ff @(posedge clk) begin
    if (func_rst) begin
      cfg_q   <= '0;
      irqen_q <= '0;
      nmi_o   <= 1'b1;
      diag_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_RSTCFG) cfg_q   <= reg_wdata;
      if (reg_we && reg_addr == A_IRQEN)  irqen_q <= reg_wdata;
      if (reg_we && reg_addr == A_IRQCTL) nmi_o   <= reg_wdata[0];
      diag_o <= reg_we && (reg_addr == A_DIAG) && reg_wdata[0];
      irq_o  <= |(stat_q & irqen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_RSTCFG: reg_rdata <= cfg_q;
        A_STAT:   reg_rdata <= stat_q;
        A_CAUSE:  reg_rdata <= N_SRC'(cause_q);
        A_IRQCTL: reg_rdata <= N_SRC'(nmi_o);
        A_IRQEN:  reg_rdata <= irqen_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign rst_req = |(stat_q & cfg_q);
  assign stat_o  = stat_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/lockstep_safety_ctrl.sv
module lockstep_safety_ctrl #(
  parameter int BUS_W   = 72,
  parameter int N_SRC   = 8,
  parameter int CMP_IDX = 5,
  parameter int RST_LEN = 16
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             cmp_en,
  input  logic [BUS_W-1:0] mst_bus,
  input  logic [BUS_W-1:0] chk_bus,
  input  logic [N_SRC-1:0] ext_err,
  input  logic [2:0]       reg_addr,
  input  logic             reg_we,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             irq_o,
  output logic             irq_nmi_o,
  output logic             diag_o,
  output logic             safety_rst_o
);
  logic             cmp_err, rst_req, func_rst, cause;
  logic [N_SRC-1:0] src, stat, clr;

  assign func_rst = por_rst | safety_rst_o;
  assign src      = ext_err | (N_SRC'(cmp_err) << CMP_IDX);

  lsc_compare #(.BUS_W(BUS_W)) cmp_i (
    .clk(clk), .rst(por_rst), .en(cmp_en),
    .a(mst_bus), .b(chk_bus), .err(cmp_err)
  );

  lsc_pulse_gen #(.RST_LEN(RST_LEN)) pulse_i (
    .clk(clk), .rst(por_rst), .req(rst_req), .busy(safety_rst_o)
  );

  lsc_regs #(.N_SRC(N_SRC)) regs_i (
    .clk(clk), .por_rst(por_rst), .func_rst(func_rst), .src(src),
    .sres_busy(safety_rst_o), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_o(stat),
    .clr_o(clr), .cause_o(cause), .rst_req(rst_req), .irq_o(irq_o),
    .nmi_o(irq_nmi_o), .diag_o(diag_o)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int BUS_W   = 72,
  parameter int N_SRC   = 8,
  parameter int CMP_IDX = 5,
  parameter int RST_LEN = 16
) (
  input logic             clk,
  input logic             por_rst,
  input logic             cmp_en,
  input logic [BUS_W-1:0] mst_bus,
  input logic [BUS_W-1:0] chk_bus,
  input logic             cmp_err,
  input logic [N_SRC-1:0] stat,
  input logic [N_SRC-1:0] clr,
  input logic             rst_req,
  input logic             cause,
  input logic             safety_rst_o,
  input logic             irq_nmi_o,
  input logic             diag_o
);
  logic [1:0]  since;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (por_rst) begin
      since  <= '0;
      hi_cnt <= '0;
    end else begin
      if (since != 2'd3) since <= since + 1'b1;
      hi_cnt <= safety_rst_o ? hi_cnt + 1'b1 : '0;
    end
  end

  // R1
  a_r1_mismatch_flags: assert property (@(posedge clk) disable iff (por_rst)
    (since >= 2'd2) && $past(cmp_en, 2) && ($past(mst_bus, 2) != $past(chk_bus, 2)) |-> cmp_err);

  // R3
  a_r3_sticky: assert property (@(posedge clk) disable iff (por_rst)
    (($past(stat) & ~$past(clr) & ~stat) == '0));

  // R4
  a_r4_masked_no_reset: assert property (@(posedge clk) disable iff (por_rst)
    !rst_req && !safety_rst_o |=> !safety_rst_o);

  // R5
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (por_rst)
    !safety_rst_o && $past(safety_rst_o) |-> hi_cnt == 16'(RST_LEN));

  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (por_rst)
    hi_cnt <= 16'(RST_LEN));

  // R6
  a_r6_cause_set: assert property (@(posedge clk) disable iff (por_rst)
    $rose(safety_rst_o) |=> cause);

  // R7
  a_r7_level_default: assert property (@(posedge clk) disable iff (por_rst)
    safety_rst_o |=> irq_nmi_o);

  // R8
  a_r8_diag_single: assert property (@(posedge clk) disable iff (por_rst)
    diag_o |=> !diag_o);

  logic unused_ok;
  assign unused_ok = ^{stat[CMP_IDX]};
endmodule

bind lockstep_safety_ctrl lsc_checker #(
  .BUS_W(BUS_W), .N_SRC(N_SRC), .CMP_IDX(CMP_IDX), .RST_LEN(RST_LEN)
) chk_i (.*);

// File: tb/lockstep_safety_ctrl_tb_top.sv
module lockstep_safety_ctrl_tb_top;
  localparam int BW = 8;
  localparam int NS = 8;
  localparam int CI = 5;
  localparam int RL = 16;

  logic          clk = 1'b0;
  logic          por_rst = 1'b1;
  logic          cmp_en = 1'b0;
  logic [BW-1:0] mst_base = '0, chk_base = '0, mst_bus;
  logic [NS-1:0] ext_err = '0;
  logic [2:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [NS-1:0] reg_wdata = '0;
  logic [NS-1:0] reg_rdata;
  logic          irq_o, irq_nmi_o, diag_o, safety_rst_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // Diagnostic pulse reaches the master core only.
  assign mst_bus = mst_base ^ BW'(diag_o);

  lockstep_safety_ctrl #(.BUS_W(BW), .N_SRC(NS), .CMP_IDX(CI), .RST_LEN(RL)) dut_i (
    .clk(clk), .por_rst(por_rst), .cmp_en(cmp_en), .mst_bus(mst_bus),
    .chk_bus(chk_base), .ext_err(ext_err), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .irq_nmi_o(irq_nmi_o), .diag_o(diag_o), .safety_rst_o(safety_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watch a window: count reset-high run, irq and diag activity.
  task automatic watch(input int n, output int rst_len, output int irq_seen,
                       output int diag_cnt, output int nmi_at_irq);
    int run;
    run = 0; rst_len = 0; irq_seen = 0; diag_cnt = 0; nmi_at_irq = 1;
    for (int k = 0; k < n; k++) begin
      if (safety_rst_o) begin run++; if (run > rst_len) rst_len = run; end
      else run = 0;
      if (irq_o && !irq_seen) begin irq_seen = 1; nmi_at_irq = int'(irq_nmi_o); end
      if (diag_o) diag_cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, rl, iq, dc, nm;
    repeat (4) @(negedge clk);
    por_rst = 1'b0;
    idle(2);

    // Reset state (R6, R7, R10)
    rd(3'd0, v); chk("R10 rstcfg reset", v, 0);
    rd(3'd1, v); chk("R10 status reset", v, 0);
    rd(3'd2, v); chk("R6 cause after power-up", v, 0);
    rd(3'd3, v); chk("R7 level reset NMI", v, 1);
    rd(3'd4, v); chk("R10 irqen reset", v, 0);
    chk("R5 no reset at start", int'(safety_rst_o), 0);

    // R10: distinct addresses
    wr(3'd0, 8'h00); wr(3'd4, 8'h5A);
    rd(3'd4, v); chk("R10 irqen readback", v, 8'h5A);
    rd(3'd0, v); chk("R10 rstcfg unaffected", v, 0);
    wr(3'd4, 8'h00);

    // R1: every bit mismatch, enable on and off
    chk_base = 8'hA5; mst_base = 8'hA5;
    for (int b = 0; b < BW; b++) begin
      for (int e = 0; e < 2; e++) begin
        @(negedge clk);
        cmp_en = e[0]; mst_base = 8'hA5 ^ (8'h01 << b);
        @(negedge clk);
        mst_base = 8'hA5; cmp_en = 1'b0;
        idle(4);
        rd(3'd1, v); chk("R1 compare sweep", v, e ? (1 << CI) : 0);
        wr(3'd1, 8'hFF);
      end
    end
    cmp_en = 1'b1; idle(6);
    rd(3'd1, v); chk("R1 equal buses no error", v, 0);
    cmp_en = 1'b0;

    // R2: each external source
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); ext_err = NS'(1) << i;
      @(negedge clk); ext_err = '0;
      idle(2);
      rd(3'd1, v); chk("R2 source sets own bit", v, 1 << i);
      wr(3'd1, 8'hFF);
      rd(3'd1, v); chk("R3 write-1 clears", v, 0);
    end

    // R3: clear ignored while source active
    @(negedge clk); ext_err = 8'h04;
    wr(3'd1, 8'h04);
    rd(3'd1, v); chk("R3 clear ignored while active", v, 8'h04);
    ext_err = '0;
    wr(3'd1, 8'h04);
    rd(3'd1, v); chk("R3 clear after release", v, 0);

    // R4/R5/R6/R7: reaction matrix over all sources
    for (int i = 0; i < NS; i++) begin
      for (int m = 0; m < 4; m++) begin
        wr(3'd3, 8'h00);
        wr(3'd4, m[0] ? NS'(1) << i : '0);
        wr(3'd0, m[1] ? NS'(1) << i : '0);
        @(negedge clk); ext_err = NS'(1) << i;
        @(negedge clk); ext_err = '0;
        watch(40, rl, iq, dc, nm);
        chk("R4 irq reaction", iq, m[0]);
        chk("R4 reset reaction", rl != 0, m[1]);
        if (m[0] && !m[1]) chk("R7 maskable level at irq", nm, 0);
        rd(3'd1, v); chk("R5 status survives", v, 1 << i);
        rd(3'd2, v); chk("R6 cause", v, m[1]);
        if (m[1]) begin
          chk("R5 pulse length", rl, RL);
          rd(3'd3, v); chk("R7 level restored", v, 1);
          rd(3'd0, v); chk("R7 rstcfg cleared", v, 0);
          rd(3'd4, v); chk("R7 irqen cleared", v, 0);
          wr(3'd2, 8'h01);
          rd(3'd2, v); chk("R6 cause W1C", v, 0);
        end
        wr(3'd0, 8'h00); wr(3'd4, 8'h00);
        wr(3'd1, 8'hFF);
      end
    end

    // R8/R9: self-test through the diagnostic pulse
    chk_base = 8'h3C; mst_base = 8'h3C; cmp_en = 1'b1;
    idle(3);
    wr(3'd3, 8'h00); wr(3'd4, 8'h20); wr(3'd0, 8'h00);
    wr(3'd5, 8'h01);
    watch(12, rl, iq, dc, nm);
    chk("R8 diag one cycle", dc, 1);
    chk("R8 compare irq", iq, 1);
    chk("R8 irq maskable level", nm, 0);
    chk("R4 masked no reset", rl, 0);
    rd(3'd1, v); chk("R8 compare flag", v, 1 << CI);
    wr(3'd0, 8'h20);
    watch(30, rl, iq, dc, nm);
    chk("R9 late enable resets", rl, RL);
    rd(3'd2, v); chk("R9 cause set", v, 1);
    rd(3'd1, v); chk("R9 flag kept", v, 1 << CI);
    rd(3'd3, v); chk("R9 level NMI again", v, 1);
    watch(20, rl, iq, dc, nm);
    chk("R4 no retrigger after reset", rl, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule